// File: doc/BRIEF.md
# Level-Crossing Event Pulse Encoder

This block sits between a level-crossing converter and a low-power transmitter. The converter produces two signals. One is a toggle that changes level each time the input crosses a threshold. The other is a direction bit that tells whether the crossing went upward. The encoder merges both into a single serial line. Each crossing becomes one burst on that line, and the burst alone identifies the crossing direction. The line drives an on-off keyed carrier, so the transmitter radiates only while the line is high. Between crossings the line stays low and nothing is sent.

Two encodings are available. In single mode, one pulse is sent per crossing, and its length gives the direction: a long pulse for a downward crossing, a short one for an upward crossing. In pair mode, meant for an impulse radio, two one-cycle pulses are sent per crossing, and the number of low cycles between them gives the direction.

Both converter signals are asynchronous, so each passes through a two-flop synchronizer. If a crossing arrives while a burst is still being sent, it waits in a one-entry queue. If a further crossing arrives while that queue is full, it is dropped, and a sticky overflow flag is raised.

Top module: `lcPulseEncoder`

## Requirements
- R1: In single mode, every change of `levelToggle`, whether rising or falling, produces exactly one pulse on `pulseOut`.
- R2: In single mode, the pulse lasts ceil(WIDE_NS/CLK_PERIOD_NS) cycles when the captured `dirUp` is 0, and ceil(NARROW_NS/CLK_PERIOD_NS) cycles when it is 1. At the default parameters this is 8 and 4 cycles.
- R3: With `pairMode` = 1, each crossing produces two pulses, each one cycle long. The number of low cycles between them is GAP_DOWN (4) for `dirUp` = 0 and GAP_UP (8) for `dirUp` = 1.
- R4: `pulseOut` is low whenever no crossing is being emitted. No pulse appears unless `levelToggle` has changed.
- R5: From a lone crossing on an idle block, `pulseOut` first goes high in the third clock cycle after the `levelToggle` change: two synchronizer flops, then the output register.
- R6: `busy` is high in every cycle in which `pulseOut` is high. It returns low once the block has no crossing left to emit.
- R7: A crossing that arrives while a burst is in progress is held in a one-entry queue. Its burst starts after exactly one low cycle following the end of the current burst, and it keeps its own captured direction.
- R8: A crossing that arrives while the queue is full is dropped, and `overflow` goes high. `overflow` stays high until reset.
- R9: The direction used for a crossing is the synchronized `dirUp` value in the cycle where the crossing is detected. Later changes of `dirUp` do not change that crossing's burst.
- R10: While reset is applied, and right after it is released, `pulseOut`, `busy` and `overflow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| levelToggle | input | 1 | Crossing toggle from the converter (asynchronous) |
| dirUp | input | 1 | Crossing direction, 1 means upward (asynchronous) |
| pairMode | input | 1 | 0 selects width encoding, 1 selects two-pulse spacing encoding |
| pulseOut | output | 1 | Serial modulation pulse for the on-off keyed carrier |
| busy | output | 1 | A crossing is being emitted |
| overflow | output | 1 | Sticky flag: a crossing was dropped because the queue was full |

## Verification
The bench builds the block with its default parameters: a 10 ns clock period, 80 ns and 40 ns pulse widths, and spacings of 4 and 8 low cycles. With these values, every burst fits in a few tens of cycles. A second and a third crossing can be issued three cycles apart, so both land inside one 8-cycle pulse. That makes the queue-then-drop path and the one-low-cycle hand-off between queued bursts reachable with short directed sequences. A pulse monitor records each pulse's width, its leading low gap and its rise cycle, so widths, spacings and the three-cycle latency are all compared against values derived from the requirements.

// File: rtl/lcpe_pkg.sv
package lcpe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FIRST,
    PH_GAP,
    PH_SECOND
  } phase_e;

  typedef struct packed {
    logic startEvt;
    logic loadGap;
    logic loadSecond;
    logic finish;
  } lcpeStrobes_t;

endpackage

// File: rtl/lcpeDatapath.sv
module lcpeDatapath
  import lcpe_pkg::*;
#(
  parameter int WIDE_CYC   = 8,
  parameter int NARROW_CYC = 4,
  parameter int GAP_DOWN   = 4,
  parameter int GAP_UP     = 8,
  parameter int CNT_W      = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         levelToggle,
  input  logic         dirUp,
  input  logic         pairMode,
  input  lcpeStrobes_t strobes,
  output logic         evtAvail,
  output logic         cntLast,
  output logic         curPair,
  output logic         pulseOut,
  output logic         overflow
);

  localparam int SYNC_N = 2;
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WIDE_CYC);
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(NARROW_CYC);
  localparam logic [CNT_W-1:0] LEN_GAPDN  = CNT_W'(GAP_DOWN);
  localparam logic [CNT_W-1:0] LEN_GAPUP  = CNT_W'(GAP_UP);
  localparam logic [CNT_W-1:0] LEN_ONE    = CNT_W'(1);

  // two-flop synchronizers for toggle (bit 0) and direction (bit 1)
  logic [SYNC_N-1:0] syncIn, syncA, syncB;
  assign syncIn = {dirUp, levelToggle};

  for (genvar g = 0; g < SYNC_N; g++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
      end else begin
        syncA[g] <= syncIn[g];
        syncB[g] <= syncA[g];
      end
    end
  end

  logic ltPrev, ltEdge, dirNow;
  assign ltEdge = syncB[0] ^ ltPrev;
  assign dirNow = syncB[1];

  always_ff @(posedge clk) begin
    if (!rstN) ltPrev <= 1'b0;
    else       ltPrev <= syncB[0];
  end

  // one-entry event queue
  logic pendValid, pendDir, evtDir, freshUsed;
  assign evtAvail  = pendValid | ltEdge;
  assign evtDir    = pendValid ? pendDir : dirNow;
  assign freshUsed = strobes.startEvt & ~pendValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendDir   <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (strobes.startEvt && pendValid) pendValid <= 1'b0;
      if (ltEdge && !freshUsed) begin
        if (pendValid && !strobes.startEvt) begin
          overflow <= 1'b1;
        end else begin
          pendValid <= 1'b1;
          pendDir   <= dirNow;
        end
      end
    end
  end

  // phase counter and output register
  logic [CNT_W-1:0] cnt;
  logic             curDir;
  assign cntLast = (cnt == LEN_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      curDir   <= 1'b0;
      curPair  <= 1'b0;
      pulseOut <= 1'b0;
    end else if (strobes.startEvt) begin
      curDir   <= evtDir;
      curPair  <= pairMode;
      pulseOut <= 1'b1;
      cnt      <= pairMode ? LEN_ONE : (evtDir ? LEN_NARROW : LEN_WIDE);
    end else if (strobes.loadGap) begin
      pulseOut <= 1'b0;
      cnt      <= curDir ? LEN_GAPUP : LEN_GAPDN;
    end else if (strobes.loadSecond) begin
      pulseOut <= 1'b1;
      cnt      <= LEN_ONE;
    end else begin
      if (strobes.finish) pulseOut <= 1'b0;
      if (cnt != '0)      cnt <= cnt - LEN_ONE;
    end
  end

  // checker: run length of the current high stretch
  logic [CNT_W:0] hiRun;
  always_ff @(posedge clk) begin
    if (!rstN)         hiRun <= '0;
    else if (pulseOut) hiRun <= hiRun + 1'b1;
    else               hiRun <= '0;
  end

  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |-> (int'(hiRun) < WIDE_CYC));                                   // R2
  AST_PAIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (curPair && $rose(pulseOut)) |=> !pulseOut);                               // R3
  AST_QUEUE_FULL_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && ltEdge && !strobes.startEvt) |=> overflow);                  // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);                                                    // R8

endmodule

// File: rtl/lcpeControl.sv
module lcpeControl
  import lcpe_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtAvail,
  input  logic         cntLast,
  input  logic         curPair,
  input  logic         pulseOut,
  output lcpeStrobes_t strobes,
  output logic         busy
);

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    unique case (phase)
      PH_IDLE: if (evtAvail) begin
        strobes.startEvt = 1'b1;
        phaseNext        = PH_FIRST;
      end
      PH_FIRST: if (cntLast) begin
        if (curPair) begin
          strobes.loadGap = 1'b1;
          phaseNext       = PH_GAP;
        end else begin
          strobes.finish = 1'b1;
          phaseNext      = PH_IDLE;
        end
      end
      PH_GAP: if (cntLast) begin
        strobes.loadSecond = 1'b1;
        phaseNext          = PH_SECOND;
      end
      PH_SECOND: if (cntLast) begin
        strobes.finish = 1'b1;
        phaseNext      = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign busy = (phase != PH_IDLE);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !pulseOut);                                         // R4
  AST_BUSY_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |-> busy);                                                        // R6

endmodule

// File: rtl/lcPulseEncoder.sv
module lcPulseEncoder
  import lcpe_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int WIDE_NS       = 80,
  parameter int NARROW_NS     = 40,
  parameter int GAP_DOWN      = 4,
  parameter int GAP_UP        = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic levelToggle,
  input  logic dirUp,
  input  logic pairMode,
  output logic pulseOut,
  output logic busy,
  output logic overflow
);

  localparam int WIDE_CYC   = (WIDE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int NARROW_CYC = (NARROW_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int MAX_A      = (WIDE_CYC > NARROW_CYC) ? WIDE_CYC : NARROW_CYC;
  localparam int MAX_B      = (GAP_UP > GAP_DOWN) ? GAP_UP : GAP_DOWN;
  localparam int MAX_LEN    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W      = $clog2(MAX_LEN + 1);

  lcpeStrobes_t strobes;
  logic evtAvail, cntLast, curPair;

  lcpeDatapath #(
    .WIDE_CYC  (WIDE_CYC),
    .NARROW_CYC(NARROW_CYC),
    .GAP_DOWN  (GAP_DOWN),
    .GAP_UP    (GAP_UP),
    .CNT_W     (CNT_W)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .levelToggle(levelToggle),
    .dirUp      (dirUp),
    .pairMode   (pairMode),
    .strobes    (strobes),
    .evtAvail   (evtAvail),
    .cntLast    (cntLast),
    .curPair    (curPair),
    .pulseOut   (pulseOut),
    .overflow   (overflow)
  );

  lcpeControl control_i (
    .clk     (clk),
    .rstN    (rstN),
    .evtAvail(evtAvail),
    .cntLast (cntLast),
    .curPair (curPair),
    .pulseOut(pulseOut),
    .strobes (strobes),
    .busy    (busy)
  );

endmodule

// File: tb/lcPulseEncoder_tb_top.sv
module lcPulseEncoder_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic levelToggle = 1'b0;
  logic dirUp = 1'b0;
  logic pairMode = 1'b0;
  logic pulseOut, busy, overflow;

  always #5 clk = ~clk;

  lcPulseEncoder dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .levelToggle(levelToggle),
    .dirUp      (dirUp),
    .pairMode   (pairMode),
    .pulseOut   (pulseOut),
    .busy       (busy),
    .overflow   (overflow)
  );

  // expected values from the requirements at default parameters
  localparam int NV = 6;
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 1, 1};
  localparam int V_DIR  [NV] = '{0, 1, 0, 1, 0, 1};
  localparam int V_W    [NV] = '{8, 4, 8, 4, 1, 1};
  localparam int V_GAP  [NV] = '{0, 0, 0, 0, 4, 8};

  int checkCnt = 0;
  int failCnt  = 0;

  // pulse monitor: sampled at the falling edge
  int cyc = 0;
  int nP = 0;
  int curW = 0;
  int lowRun = 0;
  logic prevP = 1'b0;
  int wArr [64];
  int gArr [64];
  int riseCyc [64];
  logic busyAtRise [64];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (pulseOut) begin
      if (!prevP) begin
        gArr[nP & 63]       = lowRun;
        riseCyc[nP & 63]    = cyc;
        busyAtRise[nP & 63] = busy;
        curW = 1;
      end else begin
        curW = curW + 1;
      end
    end else begin
      if (prevP) begin
        wArr[nP & 63] = curW;
        nP = nP + 1;
        lowRun = 1;
      end else begin
        lowRun = lowRun + 1;
      end
    end
    prevP = pulseOut;
  end

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic toggleAt(output int when);
    @(negedge clk);
    #1;
    when = cyc;
    levelToggle = ~levelToggle;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic runAll();
    int base, t0, t1;
    // R10: reset state
    idle(3);
    check("R10 pulse in reset", int'(pulseOut), 0);
    check("R10 busy in reset", int'(busy), 0);
    @(negedge clk); #1; rstN = 1'b1;
    idle(2);
    check("R10 overflow after reset", int'(overflow), 0);
    check("R10 pulse after reset", int'(pulseOut), 0);

    // table of single and pair events
    for (int v = 0; v < NV; v++) begin
      pairMode = V_MODE[v][0];
      dirUp    = V_DIR[v][0];
      idle(4);
      base = nP;
      toggleAt(t0);
      idle(40);
      check($sformatf("R1 R3 pulse count v%0d", v), nP - base, V_MODE[v] ? 2 : 1);
      check($sformatf("R2 R3 width v%0d", v), wArr[base & 63], V_W[v]);
      check($sformatf("R5 latency v%0d", v), riseCyc[base & 63] - t0, 3);
      check($sformatf("R6 busy at rise v%0d", v), int'(busyAtRise[base & 63]), 1);
      if (V_MODE[v] != 0) begin
        check($sformatf("R3 spacing v%0d", v), gArr[(base + 1) & 63], V_GAP[v]);
        check($sformatf("R3 second width v%0d", v), wArr[(base + 1) & 63], 1);
      end
      check($sformatf("R6 busy released v%0d", v), int'(busy), 0);
    end

    // R4: quiet window with no toggle
    pairMode = 1'b0;
    base = nP;
    idle(50);
    check("R4 no pulse without toggle", nP - base, 0);
    check("R4 line low while idle", int'(pulseOut), 0);

    // R9: direction changes after detection are ignored
    dirUp = 1'b0;
    idle(4);
    base = nP;
    toggleAt(t0);
    @(negedge clk); #1; dirUp = 1'b1;
    idle(30);
    check("R9 width uses captured dir", wArr[base & 63], 8);

    // R7: queued crossing with its own direction
    dirUp = 1'b0;
    idle(4);
    base = nP;
    toggleAt(t0);
    @(negedge clk); #1; dirUp = 1'b1;
    idle(2);
    toggleAt(t1);
    idle(40);
    check("R7 two bursts", nP - base, 2);
    check("R7 first width", wArr[base & 63], 8);
    check("R7 queued width", wArr[(base + 1) & 63], 4);
    check("R7 one low cycle between", gArr[(base + 1) & 63], 1);
    check("R8 no overflow on single queue", int'(overflow), 0);

    // R8: third crossing dropped
    dirUp = 1'b0;
    idle(4);
    base = nP;
    toggleAt(t0);
    idle(2);
    toggleAt(t1);
    idle(2);
    toggleAt(t1);
    idle(50);
    check("R8 dropped crossing", nP - base, 2);
    check("R8 overflow raised", int'(overflow), 1);
    idle(20);
    check("R8 overflow sticky", int'(overflow), 1);

    // R10: reset clears the flag
    if (levelToggle) begin
      levelToggle = 1'b0;
      idle(30);
    end
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(3);
    check("R10 overflow cleared by reset", int'(overflow), 0);
    check("R10 busy after reset", int'(busy), 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (20000) @(posedge clk);
        checkCnt++;
        failCnt++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

endmodule